// File: doc/BRIEF.md
# Asynchronous SRAM Port Sequencer

This block turns single-beat read and write requests, offered on a valid/ready handshake, into the strobe sequence that one port of an asynchronous static RAM needs: active-low chip enable, read/write and output enable, a held address, and write data with its own drive enable. Every phase length is counted in clock cycles. Each length is a parameter that the integrator derives by rounding the nanosecond limits of the chosen memory speed grade up to whole cycles, with at least one cycle per phase.

Two write styles are supported, and the choice is made per request. In the strobe-on-write style, chip enable is held low and the read/write line forms the pulse. Optionally, output enable stays low through the write, and then the pulse is stretched so the memory's outputs can turn off before data is driven. In the strobe-on-enable style, read/write falls before chip enable, chip enable forms the pulse, and read/write rises only after chip enable has returned high. For a read, the address is held with chip enable and output enable low for the access time. The bus is then sampled, and the data is returned with a one-cycle valid pulse.

Top module: `sram_port_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dout_en` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only while no transaction is in progress, and a request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. A request held on the inputs during a busy period is ignored: it writes nothing and is not counted.
- R3: With `cfg_ce_style`=0 and `cfg_oe_low`=0, a write holds `sram_ce_n` low from acceptance through recovery. After T_AS set-up cycles, `sram_we_n` is low for exactly T_WP cycles. `sram_we_n` returns to 1 while `sram_ce_n` is still 0.
- R4: With `cfg_ce_style`=0 and `cfg_oe_low`=1, `sram_oe_n` stays 0 through the write. `sram_we_n` is low for max(T_WP, T_WZ+T_DW) cycles. `sram_dout_en` first rises T_WZ cycles after `sram_we_n` falls, and it is 0 during recovery.
- R5: With `cfg_ce_style`=1, `sram_we_n` is low for T_AS cycles before `sram_ce_n` falls. `sram_ce_n` is then low for T_WP cycles and rises while `sram_we_n` is still 0. `sram_oe_n` stays 1 whatever `cfg_oe_low` is.
- R6: The address is stable while chip enable and read/write are both low. Data is driven during at least the last T_DW cycles of that overlap, and the value driven at its end is the one the request carried.
- R7: A write keeps `req_ready` at 0 for T_AS + pulse + T_WR cycles after the accepting edge.
- R8: A read keeps `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1 for T_AA access cycles plus one capture cycle, and never drives data. `rsp_valid` is then 1 for exactly one cycle, carrying the bus value from the capture cycle. `req_ready` stays 0 for T_AA+1 cycles.
- R9: The write style and the output-enable choice are taken at acceptance. Changing `cfg_ce_style` or `cfg_oe_low` during a transaction has no effect on it.
- R10: While `sram_ce_n` and `sram_oe_n` are both 0, `sram_dout_en` is 1 only if `sram_we_n` has already been 0 for at least T_WZ earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_ce_style | input | 1 | 1 = strobe-on-enable write, 0 = strobe-on-write |
| cfg_oe_low | input | 1 | 1 = keep output enable low during strobe-on-write writes |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Captured read data |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory read/write, low = write |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | AW | Memory address |
| sram_dout | output | DW | Data toward the memory |
| sram_dout_en | output | 1 | Data drive enable toward the memory |
| sram_din | input | DW | Data from the memory |

## Verification
The in-line properties assume that the memory drives `sram_din` only under the read conditions and that the surrounding logic never drives the shared data lines. They also assume that `cfg_*` and the request fields matter only on the accepting edge. The bench's memory model returns a poison value until the address has been held under read conditions for more than T_AA cycles, so an early capture is visible. It also stores data only at the end of a chip-enable/read-write overlap. The driver changes every request and configuration input while the sequencer is busy and keeps a foreign request valid during that time. It never changes the inputs in the cycle in which a request is taken.

// File: rtl/sram_seq_pkg.sv
// Shared types for the asynchronous SRAM port sequencer.
// Assumes: nothing beyond the parameters passed to the modules using it.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_STROBE,
        ST_W_RECOVER,
        ST_R_ACCESS,
        ST_R_CAPTURE
    } seq_state_e;

    // Per-transaction choices latched at acceptance
    typedef struct packed {
        logic ce_style;   // 1: chip enable forms the write pulse
        logic oe_low;     // 1: output enable held low during the write
    } txn_flags_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
// Phase sequencer: state register and phase counter.
// Presents the next state, next count and next flags so that the pin
// stage can register glitch-free strobes aligned with the state.
// Assumes: every timing parameter is at least 1.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned T_AS = 1,
    parameter int unsigned T_WP = 2,
    parameter int unsigned T_WZ = 2,
    parameter int unsigned T_DW = 2,
    parameter int unsigned T_WR = 1,
    parameter int unsigned T_AA = 3,
    parameter int unsigned CW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cfg_ce_style,
    input  logic             cfg_oe_low,
    output logic             req_ready,
    output logic             accept,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output logic [CW-1:0]    cnt_d,
    output txn_flags_t       flags_d
);

    localparam int unsigned PULSE_OEL = max2(T_WP, T_WZ + T_DW);
    localparam logic [CW-1:0] L_AS  = CW'(T_AS - 1);
    localparam logic [CW-1:0] L_WP  = CW'(T_WP - 1);
    localparam logic [CW-1:0] L_OEL = CW'(PULSE_OEL - 1);
    localparam logic [CW-1:0] L_WR  = CW'(T_WR - 1);
    localparam logic [CW-1:0] L_AA  = CW'(T_AA - 1);

    logic [CW-1:0] cnt_q;
    txn_flags_t    flags_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Latch the write style at acceptance; the OE option only applies to strobe-on-write
    always_comb begin
        flags_d = flags_q;
        if (accept) begin
            flags_d.ce_style = cfg_ce_style;
            flags_d.oe_low   = cfg_oe_low && !cfg_ce_style;
        end
    end

    // Next-state and phase-length selection
    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = req_write ? ST_W_SETUP : ST_R_ACCESS;
                    cnt_d   = req_write ? L_AS : L_AA;
                end
            end
            ST_W_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_W_STROBE;
                    cnt_d   = flags_q.oe_low ? L_OEL : L_WP;
                end
            end
            ST_W_STROBE: begin
                if (cnt_q == '0) begin
                    state_d = ST_W_RECOVER;
                    cnt_d   = L_WR;
                end
            end
            ST_W_RECOVER: begin
                if (cnt_q == '0) state_d = ST_IDLE;
            end
            ST_R_ACCESS: begin
                if (cnt_q == '0) state_d = ST_R_CAPTURE;
            end
            ST_R_CAPTURE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State, counter and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            flags_q <= flags_d;
        end
    end

    // R2: a transaction never leaves idle without a handshake
    p_leave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_IDLE) && state_q != ST_IDLE) |-> $past(req_valid));

endmodule

// File: rtl/sram_seq_pins.sv
// Strobe stage: decodes the next state into memory control levels and
// registers them, so the pins change only on clock edges and line up
// with the state register.
// Assumes: cnt_d counts down to zero inside each phase.
module sram_seq_pins
    import sram_seq_pkg::*;
#(
    parameter int unsigned T_WP = 2,
    parameter int unsigned T_WZ = 2,
    parameter int unsigned T_DW = 2,
    parameter int unsigned CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_e    state_d,
    input  logic [CW-1:0] cnt_d,
    input  txn_flags_t    flags_d,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_dout_en
);

    localparam int unsigned PULSE_OEL = max2(T_WP, T_WZ + T_DW);
    // Last count value (counting down) at which drive is still withheld is PULSE_OEL-T_WZ
    localparam logic [CW-1:0] DRIVE_FROM = CW'(PULSE_OEL - 1 - T_WZ);

    logic ce_d, we_d, oe_d, den_d;

    // Decode control levels for the coming cycle
    always_comb begin
        ce_d  = 1'b1;
        we_d  = 1'b1;
        oe_d  = 1'b1;
        den_d = 1'b0;
        case (state_d)
            ST_W_SETUP: begin
                if (flags_d.ce_style) we_d = 1'b0;
                else                  ce_d = 1'b0;
                oe_d = !flags_d.oe_low;
            end
            ST_W_STROBE: begin
                ce_d  = 1'b0;
                we_d  = 1'b0;
                oe_d  = !flags_d.oe_low;
                den_d = flags_d.oe_low ? (cnt_d <= DRIVE_FROM) : 1'b1;
            end
            ST_W_RECOVER: begin
                if (flags_d.ce_style) begin
                    we_d  = 1'b0;
                    den_d = 1'b1;
                end else begin
                    ce_d  = 1'b0;
                    oe_d  = !flags_d.oe_low;
                    den_d = !flags_d.oe_low;
                end
            end
            ST_R_ACCESS, ST_R_CAPTURE: begin
                ce_d = 1'b0;
                oe_d = 1'b0;
            end
            default: ;
        endcase
    end

    // Pin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n    <= 1'b1;
            sram_we_n    <= 1'b1;
            sram_oe_n    <= 1'b1;
            sram_dout_en <= 1'b0;
        end else begin
            sram_ce_n    <= ce_d;
            sram_we_n    <= we_d;
            sram_oe_n    <= oe_d;
            sram_dout_en <= den_d;
        end
    end

    // R4: the first strobe cycle with outputs enabled never drives data
    p_wz_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_we_n) && !sram_oe_n) |-> !sram_dout_en);

    // R10: with the memory's outputs enabled, drive only under a write strobe
    p_no_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dout_en && !sram_oe_n && !sram_ce_n) |-> !sram_we_n);

endmodule

// File: rtl/sram_seq_dpath.sv
// Address/data holding registers and read capture.
// Assumes: accept is high for exactly one cycle per transaction.
module sram_seq_dpath
    import sram_seq_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  seq_state_e    state_q,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] sram_din,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    // Hold address and write data for the whole transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dout <= '0;
        end else if (accept) begin
            sram_addr <= req_addr;
            sram_dout <= req_wdata;
        end
    end

    // Sample the bus at the end of the capture cycle and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == ST_R_CAPTURE);
            if (state_q == ST_R_CAPTURE) rsp_rdata <= sram_din;
        end
    end

    // R8: read data is flagged for a single cycle
    p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_port_seq.sv
// Top of the asynchronous SRAM port sequencer: takes valid/ready
// requests and produces cycle-counted strobes for one memory port.
// Assumes: timing parameters are nanosecond limits rounded up to
// cycles, each at least 1, and T_WP >= T_DW.
module sram_port_seq
    import sram_seq_pkg::*;
#(
    parameter int unsigned AW   = 12,
    parameter int unsigned DW   = 8,
    parameter int unsigned T_AS = 1,
    parameter int unsigned T_WP = 2,
    parameter int unsigned T_WZ = 2,
    parameter int unsigned T_DW = 2,
    parameter int unsigned T_WR = 1,
    parameter int unsigned T_AA = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          cfg_ce_style,
    input  logic          cfg_oe_low,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dout_en,
    input  logic [DW-1:0] sram_din
);

    localparam int unsigned PULSE_OEL = max2(T_WP, T_WZ + T_DW);
    localparam int unsigned MAXD = max2(max2(T_AS, PULSE_OEL), max2(T_WR, T_AA));
    localparam int unsigned CW   = $clog2(MAXD + 1);

    logic          accept;
    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    txn_flags_t    flags_d;

    sram_seq_ctrl #(
        .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW),
        .T_WR(T_WR), .T_AA(T_AA), .CW(CW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .cfg_ce_style(cfg_ce_style), .cfg_oe_low(cfg_oe_low),
        .req_ready(req_ready), .accept(accept),
        .state_q(state_q), .state_d(state_d),
        .cnt_d(cnt_d), .flags_d(flags_d)
    );

    sram_seq_pins #(
        .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .CW(CW)
    ) i_pins (
        .clk(clk), .rst_n(rst_n),
        .state_d(state_d), .cnt_d(cnt_d), .flags_d(flags_d),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dout_en(sram_dout_en)
    );

    sram_seq_dpath #(
        .AW(AW), .DW(DW)
    ) i_dpath (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .state_q(state_q),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .sram_din(sram_din),
        .sram_addr(sram_addr), .sram_dout(sram_dout),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // R2: while idle the memory is deselected and not driven
    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && !sram_dout_en));

    // R6: address holds across consecutive overlap cycles
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !sram_we_n && $past(!sram_ce_n && !sram_we_n)) |-> $stable(sram_addr));

    // R5: chip enable only falls onto an already-low read/write line
    p_ce_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_ce_n) && !sram_we_n) |-> $past(!sram_we_n));

    // R5: after an enable-formed pulse, read/write is still low
    p_we_after_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sram_ce_n) && $past(!sram_we_n)) |-> !sram_we_n);

endmodule

// File: tb/test_sram_port_seq.sv
`timescale 1ns/1ps
module test_sram_port_seq;

    localparam int AW = 12;
    localparam int DW = 8;
    localparam int T_AS = 1, T_WP = 2, T_WZ = 2, T_DW = 2, T_WR = 1, T_AA = 3;
    localparam int P_OEL = (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            pulse;
        bit            ce;
        bit            oel;
    } wexp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, cfg_ce_style = 1'b0, cfg_oe_low = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] sram_din = 8'hEE;
    logic req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en;
    logic [DW-1:0] rsp_rdata, sram_dout;
    logic [AW-1:0] sram_addr;

    int checks = 0, errors = 0, issued = 0, accepts = 0, cyc = 0;
    wexp_t wq[$];
    logic [DW-1:0] rq[$];
    logic [DW-1:0] exp_mem[int];
    logic [DW-1:0] mem_model[int];

    always #4 clk = ~clk;

    sram_port_seq i_sram_port_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_ce_style(cfg_ce_style), .cfg_oe_low(cfg_oe_low),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_dout_en(sram_dout_en),
        .sram_din(sram_din)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model and write monitor, evaluated mid-cycle
    int rd_age = 0, ov_len = 0, dv_len = 0, we_low = 0;
    logic [AW-1:0] ov_addr;
    logic [DW-1:0] ov_data;
    logic ov_oe_n;
    always @(negedge clk) begin
        if (rst_n) begin
            // R10: no drive while the memory may still be driving
            if (sram_dout_en && !sram_oe_n && !sram_ce_n)
                check(!sram_we_n && we_low >= T_WZ, "R10 drive vs outputs", we_low, T_WZ);
            we_low = sram_we_n ? 0 : we_low + 1;
            if (!sram_ce_n && !sram_we_n) begin
                if (ov_len > 0) check(sram_addr == ov_addr, "R6 address stable", sram_addr, ov_addr);
                ov_len++;
                dv_len = sram_dout_en ? dv_len + 1 : 0;
                ov_addr = sram_addr; ov_data = sram_dout; ov_oe_n = sram_oe_n;
            end else if (ov_len > 0) begin
                wexp_t e;
                if (wq.size() == 0) check(0, "R2 unexpected write", ov_addr, 0);
                else begin
                    e = wq.pop_front();
                    check(ov_len == e.pulse, e.ce ? "R5 pulse" : (e.oel ? "R4 pulse" : "R3 pulse"), ov_len, e.pulse);
                    check(ov_addr == e.a, "R6 address", ov_addr, e.a);
                    check(ov_data == e.d && dv_len >= T_DW, "R6 data", ov_data, e.d);
                    check(ov_oe_n == !e.oel, e.ce ? "R5 oe ignored" : "R4 oe level", ov_oe_n, !e.oel);
                    if (e.ce) check(sram_ce_n && !sram_we_n, "R5 end order", {sram_ce_n, sram_we_n}, 2'b10);
                    else      check(!sram_ce_n && sram_we_n, "R3 end order", {sram_ce_n, sram_we_n}, 2'b01);
                end
                if (dv_len >= T_DW) mem_model[int'(ov_addr)] = ov_data;
                ov_len = 0; dv_len = 0;
            end
            if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_age++; else rd_age = 0;
            if (rd_age > T_AA)
                sram_din = mem_model.exists(int'(sram_addr)) ? mem_model[int'(sram_addr)] : '0;
            else
                sram_din = 8'hEE;
            // R8: returned read data against the scoreboard
            if (rsp_valid) begin
                if (rq.size() == 0) check(0, "R8 unexpected response", rsp_rdata, 0);
                else begin
                    logic [DW-1:0] x;
                    x = rq.pop_front();
                    check(rsp_rdata == x, "R8 read data", rsp_rdata, x);
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && req_valid && req_ready) accepts++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R7 watchdog cycles=%0d expected<=%0d", cyc, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: one request; disturbs the inputs while busy (R9, R2)
    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit ce, input bit oel, input bit stuff);
        int busy, exp_busy, pulse;
        wexp_t e;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        cfg_ce_style = ce; cfg_oe_low = oel;
        while (!req_ready) @(negedge clk);
        pulse = (!ce && oel) ? P_OEL : T_WP;
        exp_busy = wr ? T_AS + pulse + T_WR : T_AA + 1;
        if (wr) begin
            e.a = a; e.d = d; e.pulse = pulse; e.ce = ce; e.oel = oel && !ce;
            wq.push_back(e);
            exp_mem[int'(a)] = d;
        end else rq.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0);
        issued++;
        @(negedge clk);
        cfg_ce_style = !ce; cfg_oe_low = !oel;
        if (stuff) begin req_write = 1; req_addr = a ^ '1; req_wdata = ~d; end
        else req_valid = 0;
        busy = 0;
        while (!req_ready) begin
            busy++;
            if (busy >= exp_busy) req_valid = 0;
            check(!req_ready, "R2 busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 0;
        check(busy == exp_busy, wr ? "R7 write busy" : "R8 read busy", busy, exp_busy);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dout_en && !rsp_valid && req_ready,
              "R1 reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en, rsp_valid, req_ready}, 6'b111001);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(sram_ce_n && sram_we_n && !sram_dout_en && req_ready, "R1 after reset",
              {sram_ce_n, sram_we_n, sram_dout_en, req_ready}, 4'b1101);
        do_req(1, 12'h000, 8'h5A, 0, 0, 0);     // R3 lowest address
        do_req(1, 12'hFFF, 8'hA5, 0, 0, 0);     // R3 highest address
        do_req(1, 12'h456, 8'h3C, 0, 1, 0);     // R4 stretched pulse
        do_req(1, 12'h789, 8'hC3, 1, 1, 0);     // R5 with OE option ignored
        do_req(1, 12'h0F0, 8'h77, 1, 0, 1);     // R2 foreign request held while busy
        for (int i = 0; i < 6; i++)
            do_req(1, 12'(16 + i * 37), 8'(i * 29 + 1), i[0], i[1], 0);  // R9 mode mix
        do_req(0, 12'h000, 8'h00, 0, 0, 0);
        do_req(0, 12'hFFF, 8'h00, 1, 0, 0);
        do_req(0, 12'h456, 8'h00, 0, 1, 0);
        do_req(0, 12'h789, 8'h00, 0, 0, 0);
        do_req(0, 12'h0F0, 8'h00, 0, 0, 1);
        do_req(0, 12'hF0F, 8'h00, 0, 0, 0);     // R2 stuffed address left unwritten
        for (int i = 0; i < 6; i++)
            do_req(0, 12'(16 + i * 37), 8'h00, 0, 0, 0);
        repeat (4) @(negedge clk);
        check(accepts == issued, "R2 accept count", accepts, issued);
        check(wq.size() == 0 && rq.size() == 0, "R8 scoreboard drained", wq.size() + rq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule